// File: doc/BRIEF.md
# Scratch-Pad Tag Match and Fetch Router

This block sits in the instruction fetch path in front of the instruction cache. Each fetch carries a 26-bit address: a 24-bit byte address with a 2-bit section attribute placed above it in bits 25:24. The block first compares the fetch against four tag registers, one per scratch-pad page, all in parallel. When a tag matches, the fetch is sent to the on-chip scratch-pad together with the page number and the offset inside the 32 KB page. When no tag matches, the section attribute picks the miss path: normal two-way cache lookup, a fill restricted to way 0, a fill restricted to way 1, or a direct uncached fetch from external memory.

Tag registers are written through a simple configuration port. Each 9-bit tag holds a valid flag, the 2-bit attribute the section must carry, and the 6-bit section address. The block does not hold the cache or scratch-pad storage. It only produces the routing decision one clock after the request.

The decision is held in a small state machine whose state is the kind of the last response. The states are `RSP_IDLE`, `RSP_SPAD`, `RSP_CACHE_2WAY`, `RSP_FILL_WAY0`, `RSP_FILL_WAY1` and `RSP_BYPASS`. Reset enters `RSP_IDLE`. On every clock edge a cycle with no request goes to `RSP_IDLE`. A request that hits goes to `RSP_SPAD`. A request that misses goes to `RSP_CACHE_2WAY`, `RSP_FILL_WAY0`, `RSP_FILL_WAY1` or `RSP_BYPASS` for attribute 00, 01, 10 or 11. These transitions are taken from any state.

Top module: `spad_fetch_router`

## Requirements
- R1: Reset clears every tag register, valid flag included, so no fetch hits until a tag with its valid bit set has been written; after reset `rsp_valid` is 0.
- R2: A fetch presented with `fetch_req` high on a clock edge produces `rsp_valid` high for exactly the following cycle; a cycle without a request gives `rsp_valid` low in the following cycle.
- R3: A page matches when its tag bit 8 (valid) is 1, tag bits 7:6 equal fetch bits 25:24, and tag bits 5:0 equal fetch bits 20:15; fetch bits 23:21 take no part in the comparison.
- R4: On a hit, `rsp_hit` is 1, `rsp_page` gives the matching page number and `rsp_route` is 00.
- R5: On a miss, `rsp_hit` is 0, `rsp_page` is 0 and `rsp_route` equals fetch bits 25:24: 00 two-way cache lookup, 01 fill way 0 only, 10 fill way 1 only, 11 uncached external fetch.
- R6: `rsp_offset` equals fetch bits 14:0 on both hits and misses.
- R7: When several pages match, the lowest-numbered one is reported and `rsp_multi` is 1; with a single match `rsp_multi` is 0.
- R8: A tag write is seen by fetches from the next clock on; a fetch in the same cycle as the write compares against the old tag, and writing a tag with bit 8 clear takes that page out of matching.
- R9: While `rsp_valid` is 0, `rsp_hit`, `rsp_page`, `rsp_route`, `rsp_offset` and `rsp_multi` are all 0.
- R10: A fetch whose bits 20:15 equal a valid tag's address field but whose attribute bits differ from the tag's is a miss.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Tag register write strobe |
| cfg_page | input | 2 | Page whose tag is written |
| cfg_tag | input | 9 | Tag value: bit 8 valid, bits 7:6 attribute, bits 5:0 section address |
| fetch_req | input | 1 | Fetch request strobe |
| fetch_addr | input | 26 | Fetch address: bits 25:24 attribute, bits 23:0 byte address |
| rsp_valid | output | 1 | Routing decision valid |
| rsp_hit | output | 1 | Fetch served from scratch-pad |
| rsp_page | output | 2 | Scratch-pad page on a hit |
| rsp_route | output | 2 | Miss path code, 00 on a hit |
| rsp_offset | output | 15 | Byte offset within the page |
| rsp_multi | output | 1 | More than one tag matched |

## Verification
On every cycle, the assertions check the one-cycle request-to-response timing and that a hit or miss decision is carried correctly into the route code, page and offset. They also check that the reported page really matches and that no lower page also matched, that the multi-hit flag appears only with two or more matches, and that the outputs stay quiet when idle. Whether the tag layout is decoded correctly is shown only by the bench's scenarios: the bits 23:21 that are ignored, the valid bit, and the attribute mismatch. The same holds for reset clearing the tags, a write in the same cycle as a fetch seeing the old tag, and invalidation through a tag write.

// File: rtl/spr_pkg.sv
package spr_pkg;

    // Kind of the response currently presented
    typedef enum logic [2:0] {
        RSP_IDLE       = 3'd0,
        RSP_SPAD       = 3'd1,
        RSP_CACHE_2WAY = 3'd2,
        RSP_FILL_WAY0  = 3'd3,
        RSP_FILL_WAY1  = 3'd4,
        RSP_BYPASS     = 3'd5
    } rsp_state_e;

    // Route codes; numerically equal to the section attribute on a miss
    typedef enum logic [1:0] {
        ROUTE_CACHE  = 2'd0,
        ROUTE_WAY0   = 2'd1,
        ROUTE_WAY1   = 2'd2,
        ROUTE_BYPASS = 2'd3
    } route_e;

endpackage

// File: rtl/spr_tag_bank.sv
module spr_tag_bank #(
    parameter int PAGES = 4,
    parameter int TAG_W = 9,
    localparam int IDX_W = $clog2(PAGES)
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   cfg_we,
    input  logic [IDX_W-1:0]       cfg_page,
    input  logic [TAG_W-1:0]       cfg_tag,
    output logic [PAGES*TAG_W-1:0] tags_o
);

    generate
        for (genvar p = 0; p < PAGES; p++) begin : g_page
            logic [TAG_W-1:0] tag_q;

            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    tag_q <= '0;
                end else if (cfg_we && cfg_page == IDX_W'(p)) begin
                    tag_q <= cfg_tag;
                end
            end

            assign tags_o[p*TAG_W +: TAG_W] = tag_q;
        end
    endgenerate

    // Written value appears in the addressed slot on the next cycle
    assert_tag_write_lands_R8: assert property (
        @(posedge clk) disable iff (!rst_n)
        cfg_we |=> tags_o[$past(cfg_page)*TAG_W +: TAG_W] == $past(cfg_tag)
    );

endmodule

// File: rtl/spr_tag_match.sv
module spr_tag_match #(
    parameter int PAGES      = 4,
    parameter int ATTR_W     = 2,
    parameter int BYTE_W     = 24,
    parameter int OFF_W      = 15,
    parameter int TAG_ADDR_W = 6,
    localparam int IDX_W   = $clog2(PAGES),
    localparam int TAG_W   = 1 + ATTR_W + TAG_ADDR_W,
    localparam int FETCH_W = ATTR_W + BYTE_W
) (
    input  logic [PAGES*TAG_W-1:0] tags_i,
    input  logic [FETCH_W-1:0]     fetch_addr_i,
    output logic                   hit_o,
    output logic [IDX_W-1:0]       page_o,
    output logic                   multi_o
);

    logic [ATTR_W-1:0]     fetch_attr;
    logic [TAG_ADDR_W-1:0] fetch_sect;
    logic [PAGES-1:0]      match_vec;

    assign fetch_attr = fetch_addr_i[FETCH_W-1 -: ATTR_W];
    assign fetch_sect = fetch_addr_i[OFF_W +: TAG_ADDR_W];

    generate
        for (genvar p = 0; p < PAGES; p++) begin : g_cmp
            logic [TAG_W-1:0] tag;
            assign tag = tags_i[p*TAG_W +: TAG_W];
            assign match_vec[p] = tag[TAG_W-1]
                               && (tag[TAG_ADDR_W +: ATTR_W] == fetch_attr)
                               && (tag[TAG_ADDR_W-1:0] == fetch_sect);
        end
    endgenerate

    // Lowest-numbered matching page wins
    always_comb begin
        page_o = '0;
        for (int i = PAGES - 1; i >= 0; i--) begin
            if (match_vec[i]) page_o = IDX_W'(i);
        end
        hit_o   = |match_vec;
        multi_o = ($countones(match_vec) > 1);
    end

    always_comb begin
        assert_sel_page_matches_R3: assert (!hit_o || match_vec[page_o]);
        assert_lowest_page_wins_R7: assert (!hit_o || ((match_vec & ((PAGES'(1) << page_o) - PAGES'(1))) == '0));
        assert_multi_needs_two_R7: assert (!multi_o || (hit_o && !$onehot0(match_vec)));
    end

endmodule

// File: rtl/spr_route_fsm.sv
module spr_route_fsm
    import spr_pkg::*;
#(
    parameter int PAGES  = 4,
    parameter int ATTR_W = 2,
    parameter int OFF_W  = 15,
    localparam int IDX_W = $clog2(PAGES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              fetch_req,
    input  logic              hit_i,
    input  logic [IDX_W-1:0]  page_i,
    input  logic              multi_i,
    input  logic [ATTR_W-1:0] attr_i,
    input  logic [OFF_W-1:0]  offset_i,
    output logic              rsp_valid,
    output logic              rsp_hit,
    output logic [IDX_W-1:0]  rsp_page,
    output logic [1:0]        rsp_route,
    output logic [OFF_W-1:0]  rsp_offset,
    output logic              rsp_multi
);

    rsp_state_e        state_q, state_d;
    logic [IDX_W-1:0]  page_q;
    logic [OFF_W-1:0]  off_q;
    logic              multi_q;

    // Next-state selection
    always_comb begin
        state_d = RSP_IDLE;
        if (fetch_req) begin
            if (hit_i) begin
                state_d = RSP_SPAD;
            end else begin
                unique case (route_e'(attr_i[1:0]))
                    ROUTE_CACHE:  state_d = RSP_CACHE_2WAY;
                    ROUTE_WAY0:   state_d = RSP_FILL_WAY0;
                    ROUTE_WAY1:   state_d = RSP_FILL_WAY1;
                    ROUTE_BYPASS: state_d = RSP_BYPASS;
                    default:      state_d = RSP_IDLE;
                endcase
            end
        end
    end

    // State register and captured fields
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= RSP_IDLE;
            page_q  <= '0;
            off_q   <= '0;
            multi_q <= 1'b0;
        end else begin
            state_q <= state_d;
            page_q  <= (fetch_req && hit_i) ? page_i : '0;
            off_q   <= fetch_req ? offset_i : '0;
            multi_q <= fetch_req && multi_i;
        end
    end

    // Outputs from state
    always_comb begin
        rsp_valid  = 1'b1;
        rsp_hit    = 1'b0;
        rsp_route  = ROUTE_CACHE;
        rsp_page   = page_q;
        rsp_offset = off_q;
        rsp_multi  = multi_q;
        unique case (state_q)
            RSP_IDLE: begin
                rsp_valid  = 1'b0;
                rsp_page   = '0;
                rsp_offset = '0;
                rsp_multi  = 1'b0;
            end
            RSP_SPAD:       rsp_hit   = 1'b1;
            RSP_CACHE_2WAY: rsp_route = ROUTE_CACHE;
            RSP_FILL_WAY0:  rsp_route = ROUTE_WAY0;
            RSP_FILL_WAY1:  rsp_route = ROUTE_WAY1;
            RSP_BYPASS:     rsp_route = ROUTE_BYPASS;
            default:        rsp_valid = 1'b0;
        endcase
    end

    assert_resp_follows_req_R2: assert property (
        @(posedge clk) disable iff (!rst_n) fetch_req |=> rsp_valid);
    assert_idle_after_gap_R2: assert property (
        @(posedge clk) disable iff (!rst_n) !fetch_req |=> !rsp_valid);
    assert_hit_carried_R4: assert property (
        @(posedge clk) disable iff (!rst_n)
        (fetch_req && hit_i) |=> (rsp_hit && rsp_page == $past(page_i) && rsp_route == 2'd0));
    assert_miss_route_R5: assert property (
        @(posedge clk) disable iff (!rst_n)
        (fetch_req && !hit_i) |=> (!rsp_hit && rsp_page == '0 && rsp_route == $past(attr_i)));
    assert_offset_carried_R6: assert property (
        @(posedge clk) disable iff (!rst_n)
        fetch_req |=> rsp_offset == $past(offset_i));
    assert_multi_with_hit_R7: assert property (
        @(posedge clk) disable iff (!rst_n) rsp_multi |-> rsp_hit);
    assert_quiet_when_idle_R9: assert property (
        @(posedge clk) disable iff (!rst_n)
        !rsp_valid |-> (!rsp_hit && rsp_page == '0 && rsp_route == 2'd0 && rsp_offset == '0 && !rsp_multi));

endmodule

// File: rtl/spad_fetch_router.sv
module spad_fetch_router #(
    parameter int PAGES      = 4,
    parameter int ATTR_W     = 2,
    parameter int BYTE_W     = 24,
    parameter int OFF_W      = 15,
    parameter int TAG_ADDR_W = 6,
    localparam int IDX_W   = $clog2(PAGES),
    localparam int TAG_W   = 1 + ATTR_W + TAG_ADDR_W,
    localparam int FETCH_W = ATTR_W + BYTE_W
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cfg_we,
    input  logic [IDX_W-1:0]   cfg_page,
    input  logic [TAG_W-1:0]   cfg_tag,
    input  logic               fetch_req,
    input  logic [FETCH_W-1:0] fetch_addr,
    output logic               rsp_valid,
    output logic               rsp_hit,
    output logic [IDX_W-1:0]   rsp_page,
    output logic [1:0]         rsp_route,
    output logic [OFF_W-1:0]   rsp_offset,
    output logic               rsp_multi
);

    logic [PAGES*TAG_W-1:0] tags;
    logic                   hit;
    logic [IDX_W-1:0]       page;
    logic                   multi;

    spr_tag_bank #(.PAGES(PAGES), .TAG_W(TAG_W)) u_bank (
        .clk      (clk),
        .rst_n    (rst_n),
        .cfg_we   (cfg_we),
        .cfg_page (cfg_page),
        .cfg_tag  (cfg_tag),
        .tags_o   (tags)
    );

    spr_tag_match #(
        .PAGES(PAGES), .ATTR_W(ATTR_W), .BYTE_W(BYTE_W),
        .OFF_W(OFF_W), .TAG_ADDR_W(TAG_ADDR_W)
    ) u_match (
        .tags_i       (tags),
        .fetch_addr_i (fetch_addr),
        .hit_o        (hit),
        .page_o       (page),
        .multi_o      (multi)
    );

    spr_route_fsm #(.PAGES(PAGES), .ATTR_W(ATTR_W), .OFF_W(OFF_W)) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .fetch_req  (fetch_req),
        .hit_i      (hit),
        .page_i     (page),
        .multi_i    (multi),
        .attr_i     (fetch_addr[FETCH_W-1 -: ATTR_W]),
        .offset_i   (fetch_addr[OFF_W-1:0]),
        .rsp_valid  (rsp_valid),
        .rsp_hit    (rsp_hit),
        .rsp_page   (rsp_page),
        .rsp_route  (rsp_route),
        .rsp_offset (rsp_offset),
        .rsp_multi  (rsp_multi)
    );

endmodule

// File: tb/spad_fetch_router_test.sv
`timescale 1ns/1ps
module spad_fetch_router_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [1:0]  cfg_page = '0;
    logic [8:0]  cfg_tag = '0;
    logic        fetch_req = 1'b0;
    logic [25:0] fetch_addr = '0;
    logic        rsp_valid, rsp_hit, rsp_multi;
    logic [1:0]  rsp_page, rsp_route;
    logic [14:0] rsp_offset;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    spad_fetch_router uut (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_page(cfg_page),
        .cfg_tag(cfg_tag), .fetch_req(fetch_req), .fetch_addr(fetch_addr),
        .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_page(rsp_page),
        .rsp_route(rsp_route), .rsp_offset(rsp_offset), .rsp_multi(rsp_multi)
    );

    // {addr[25:0], hit, page[1:0], route[1:0], multi}
    localparam int NV = 8;
    localparam logic [31:0] VEC [NV] = '{
        {2'd0, 3'd0, 6'h05, 15'h1234, 1'b1, 2'd0, 2'd0, 1'b0},  // R4 page 0
        {2'd0, 3'd7, 6'h05, 15'h7FFF, 1'b1, 2'd0, 2'd0, 1'b0},  // R3 bits 23:21 ignored
        {2'd1, 3'd2, 6'h2A, 15'h0000, 1'b1, 2'd1, 2'd0, 1'b0},  // R4 page 1
        {2'd3, 3'd0, 6'h3F, 15'h0ABC, 1'b1, 2'd2, 2'd0, 1'b0},  // R4 page 2
        {2'd2, 3'd0, 6'h01, 15'h0001, 1'b0, 2'd0, 2'd2, 1'b0},  // R3 invalid page 3 -> R5 way1
        {2'd1, 3'd0, 6'h05, 15'h0100, 1'b0, 2'd0, 2'd1, 1'b0},  // R10 attr mismatch
        {2'd0, 3'd0, 6'h06, 15'h0002, 1'b0, 2'd0, 2'd0, 1'b0},  // R5 two-way
        {2'd3, 3'd0, 6'h00, 15'h4000, 1'b0, 2'd0, 2'd3, 1'b0}   // R5 bypass
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic write_tag(input logic [1:0] pg, input logic [8:0] tg);
        @(negedge clk);
        cfg_we = 1'b1; cfg_page = pg; cfg_tag = tg;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    // Drive one fetch, return with the response on the outputs
    task automatic fetch(input logic [25:0] a);
        @(negedge clk);
        fetch_req = 1'b1; fetch_addr = a;
        @(negedge clk);
        fetch_req = 1'b0; fetch_addr = '0;
    endtask

    task automatic expect_rsp(input string req, input logic hit, input logic [1:0] pg,
                              input logic [1:0] rt, input logic [14:0] off, input logic mul);
        chk({req, " valid"}, 32'(rsp_valid), 32'd1);
        chk({req, " hit"}, 32'(rsp_hit), 32'(hit));
        chk({req, " page"}, 32'(rsp_page), 32'(pg));
        chk({req, " route"}, 32'(rsp_route), 32'(rt));
        chk({req, " offset R6"}, 32'(rsp_offset), 32'(off));
        chk({req, " multi"}, 32'(rsp_multi), 32'(mul));
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    endtask

    initial begin
        repeat (10000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog expired actual=running expected=finished");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: quiet after reset
        chk("R1 valid after reset", 32'(rsp_valid), 32'd0);
        chk("R9 outputs idle", {rsp_hit, rsp_page, rsp_route, rsp_offset, rsp_multi}, 32'd0);
        // R1: cleared tags (all-zero fields) must not hit
        fetch({2'd0, 3'd0, 6'h00, 15'h0007});
        expect_rsp("R1 no hit before write", 1'b0, 2'd0, 2'd0, 15'h0007, 1'b0);

        write_tag(2'd0, 9'h105);
        write_tag(2'd1, 9'h16A);
        write_tag(2'd2, 9'h1FF);
        write_tag(2'd3, 9'h081);

        for (int i = 0; i < NV; i++) begin
            fetch(VEC[i][31:6]);
            expect_rsp($sformatf("R3/R4/R5 vec%0d", i), VEC[i][5], VEC[i][4:3],
                       VEC[i][2:1], VEC[i][20:6], VEC[i][0]);
        end

        // R2/R9: gap cycle gives no response
        @(negedge clk);
        chk("R2 no response after gap", 32'(rsp_valid), 32'd0);
        chk("R9 outputs idle after gap", {rsp_hit, rsp_page, rsp_route, rsp_offset, rsp_multi}, 32'd0);

        // R2: back-to-back requests
        @(negedge clk);
        fetch_req = 1'b1; fetch_addr = {2'd1, 3'd0, 6'h2A, 15'h0011};
        @(negedge clk);
        expect_rsp("R2 back-to-back first", 1'b1, 2'd1, 2'd0, 15'h0011, 1'b0);
        fetch_addr = {2'd3, 3'd0, 6'h10, 15'h0022};
        @(negedge clk);
        fetch_req = 1'b0; fetch_addr = '0;
        expect_rsp("R2 back-to-back second", 1'b0, 2'd0, 2'd3, 15'h0022, 1'b0);

        // R7: page 3 duplicates page 2
        write_tag(2'd3, 9'h1FF);
        fetch({2'd3, 3'd0, 6'h3F, 15'h0005});
        expect_rsp("R7 multi-hit lowest", 1'b1, 2'd2, 2'd0, 15'h0005, 1'b1);

        // R8: write and fetch in the same cycle see the old tag
        @(negedge clk);
        cfg_we = 1'b1; cfg_page = 2'd0; cfg_tag = 9'h107;
        fetch_req = 1'b1; fetch_addr = {2'd0, 3'd0, 6'h07, 15'h0009};
        @(negedge clk);
        cfg_we = 1'b0; fetch_req = 1'b0; fetch_addr = '0;
        expect_rsp("R8 same-cycle old tag", 1'b0, 2'd0, 2'd0, 15'h0009, 1'b0);
        fetch({2'd0, 3'd0, 6'h07, 15'h0009});
        expect_rsp("R8 new tag hits", 1'b1, 2'd0, 2'd0, 15'h0009, 1'b0);
        fetch({2'd0, 3'd0, 6'h05, 15'h0009});
        expect_rsp("R8 old tag gone", 1'b0, 2'd0, 2'd0, 15'h0009, 1'b0);

        // R8: invalidate page 1
        write_tag(2'd1, 9'h06A);
        fetch({2'd1, 3'd0, 6'h2A, 15'h0003});
        expect_rsp("R8 invalidated page", 1'b0, 2'd0, 2'd1, 15'h0003, 1'b0);

        // R1: reset again clears tags
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        chk("R1 valid after second reset", 32'(rsp_valid), 32'd0);
        fetch({2'd3, 3'd0, 6'h3F, 15'h0004});
        expect_rsp("R1 tags cleared by reset", 1'b0, 2'd0, 2'd3, 15'h0004, 1'b0);

        finish_run();
    end

endmodule